// File: doc/BRIEF.md
# Serial Slave Shifter with Echo Forwarding

This block is the receiving end of a three-wire synchronous serial link plus a select line. An external master supplies the shift clock and an active-low select. While selected, the block takes one bit from the master on each rising shift-clock edge and presents one bit back, changing it on each falling edge. A frame is either 8 or 16 bits long, chosen by a width input. The serial pins are brought into the system clock through two-flop synchronisers, so all internal state runs on the system clock. The shift clock must therefore run well below the system clock. The bench uses a shift-clock half period of eight system cycles.

On the host side there is a transmit holding register with a valid flag and a receive buffer. A completed word that arrives while the buffer is still unread is parked in the shifter, and the block reports busy until the host reads the buffer. Three conditions can drive the single interrupt line, each with its own enable: idle, receive buffer full, and overrun. With echo enabled, a frame that starts with no valid transmit word forwards the incoming serial data straight back out.

Top module: `mws_slave`

## Requirements
- R1: `miso_oe_o` is 1 exactly while `cs_n_i` is 0. `miso_o` is 0 while deselected.
- R2: A frame completes after 8 rising shift-clock edges when `wide_i`=0 and after 16 when `wide_i`=1. The first bit received becomes the most significant bit of the word. In 8-bit frames, bits 15:8 of `rx_data_o` read as 0.
- R3: Transmit data leaves most significant bit first. An 8-bit frame starts from bit 7 of the transmit word and a 16-bit frame starts from bit 15. The next bit appears after each falling edge.
- R4: Writing `tx_data_i` with `tx_wr_i` sets `tx_valid_o`. The flag clears when a frame loads that word into the shifter. Loading happens when select goes active, or on the falling edge after the last bit of a frame while select stays active.
- R5: When `echo_en_i`=1 and no valid transmit word exists at frame load, `miso_o` follows `mosi_i` for the whole frame. The incoming data is still received.
- R6: When `echo_en_i`=0 and no valid word exists, the frame transmits the last word written, which may be stale.
- R7: Raising `cs_n_i` mid-frame discards the partial frame and resets the bit count. The next frame aligns to its own first edge.
- R8: A completed frame sets `rbf_o` and places the word on `rx_data_o`. A one-cycle `rx_rd_i` clears `rbf_o` when no word is parked.
- R9: A frame that completes while `rbf_o`=1 is parked and `busy_o` stays 1. A read then moves the parked word to `rx_data_o` one cycle later, and `rbf_o` stays 1.
- R10: The first bit of a new frame, arriving while `rbf_o`=1 and a word is parked, sets `ovr_o` and drops the parked word. `ovr_clr_i` clears `ovr_o`.
- R11: `irq_o` is the OR of (`ie_idle_i` and not `busy_o`), (`ie_rbf_i` and `rbf_o`), and (`ie_ovr_i` and `ovr_o`).
- R12: With select held active, back-to-back frames each load the transmit word present at their own load point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Shift clock from the master |
| cs_n_i | input | 1 | Active-low select |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for the serial data pad |
| wide_i | input | 1 | 1 selects 16-bit frames, 0 selects 8-bit frames |
| echo_en_i | input | 1 | Enables echo forwarding |
| ie_idle_i | input | 1 | Interrupt enable for not busy |
| ie_rbf_i | input | 1 | Interrupt enable for receive buffer full |
| ie_ovr_i | input | 1 | Interrupt enable for overrun |
| tx_wr_i | input | 1 | Write strobe for the transmit register |
| tx_data_i | input | WIDTH | Transmit word |
| rx_rd_i | input | 1 | Read strobe for the receive buffer |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| rx_data_o | output | WIDTH | Receive buffer contents |
| tx_valid_o | output | 1 | Transmit register holds an unsent word |
| busy_o | output | 1 | Frame in progress or word parked |
| rbf_o | output | 1 | Receive buffer full |
| ovr_o | output | 1 | Overrun flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The errors to look for are a bit count that drifts, or a parked-word flag that goes wrong. A drifting count shows in the very next frame as a received word shifted by one or more positions and as a misaligned transmit pattern. A stuck parked-word flag shows at the next buffer read: either the second word never appears on `rx_data_o`, or `busy_o` does not drop. A wrong echo decision latched at frame load shows within one bit period, because `miso_o` diverges from either `mosi_i` or the stored word on the first sampled bit.

// File: rtl/mws_pkg.sv
package mws_pkg;
  // number of shift clocks in a frame for the selected width
  function automatic int frame_len(input logic wide, input int w, input int n);
    return wide ? w : n;
  endfunction

  // bit of the shift register that is presented first
  function automatic int out_idx(input logic wide, input int w, input int n);
    return wide ? (w - 1) : (n - 1);
  endfunction

  // clear the bits above a narrow frame
  function automatic logic [15:0] narrow_mask(input logic wide, input int n);
    logic [15:0] m;
    m = '0;
    for (int i = 0; i < 16; i++) m[i] = wide || (i < n);
    return m;
  endfunction
endpackage

// File: rtl/mws_sync.sv
module mws_sync #(
  parameter int BITS   = 1,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BITS-1:0] d_i,
  output logic [BITS-1:0] q_o
);
  logic [BITS-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/mws_shifter.sv
module mws_shifter
  import mws_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int NARROW = 8,
  localparam int CW    = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_act,
  input  logic             cs_start,
  input  logic             rise,
  input  logic             fall,
  input  logic             mosi_s,
  input  logic             wide,
  input  logic             echo_en,
  input  logic [WIDTH-1:0] tx_word,
  input  logic             tx_valid,
  output logic             tx_take,
  output logic             frm_start,
  output logic             frm_done,
  output logic [WIDTH-1:0] rx_word,
  output logic             out_bit,
  output logic             echo_act,
  output logic [CW-1:0]    bit_cnt
);
  logic [WIDTH-1:0] tx_sh, rx_sh;
  logic             reload_pend;
  logic             load;
  logic             last_bit;
  logic [CW-1:0]    last_cnt;

  assign last_cnt  = CW'(frame_len(wide, WIDTH, NARROW) - 1);
  assign last_bit  = (bit_cnt == last_cnt);
  assign load      = cs_start | (fall & reload_pend);
  assign tx_take   = load & tx_valid;
  assign frm_start = rise & (bit_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh       <= '0;
      rx_sh       <= '0;
      bit_cnt     <= '0;
      reload_pend <= 1'b0;
      echo_act    <= 1'b0;
      frm_done    <= 1'b0;
    end else begin
      frm_done <= 1'b0;
      if (!cs_act) begin
        bit_cnt     <= '0;
        reload_pend <= 1'b0;
      end else begin
        if (load) begin
          tx_sh       <= tx_word;
          echo_act    <= echo_en & ~tx_valid;
          reload_pend <= 1'b0;
        end else if (fall && bit_cnt != '0) begin
          tx_sh <= tx_sh << 1;
        end
        if (rise) begin
          rx_sh <= {rx_sh[WIDTH-2:0], mosi_s};
          if (last_bit) begin
            bit_cnt     <= '0;
            frm_done    <= 1'b1;
            reload_pend <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end

  assign out_bit = tx_sh[out_idx(wide, WIDTH, NARROW)];
  assign rx_word = rx_sh & WIDTH'(narrow_mask(wide, NARROW));
endmodule

// File: rtl/mws_status.sv
module mws_status #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_done,
  input  logic             frm_start,
  input  logic [WIDTH-1:0] rx_word,
  input  logic             rx_rd,
  input  logic             ovr_clr,
  input  logic             shifting,
  output logic [WIDTH-1:0] rx_buf,
  output logic             rbf,
  output logic             shf,
  output logic             ovr,
  output logic             busy
);
  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] buf_n, hold_n;
  logic             rbf_n, shf_n, ovr_set;

  always_comb begin
    buf_n   = rx_buf;
    hold_n  = hold_q;
    rbf_n   = rbf;
    shf_n   = shf;
    ovr_set = 1'b0;
    if (rx_rd) begin
      if (shf) begin
        buf_n = hold_q;
        shf_n = 1'b0;
      end else begin
        rbf_n = 1'b0;
      end
    end
    if (frm_start && shf_n && rbf_n) begin
      ovr_set = 1'b1;
      shf_n   = 1'b0;
    end
    if (frm_done) begin
      if (!rbf_n) begin
        buf_n = rx_word;
        rbf_n = 1'b1;
      end else begin
        hold_n = rx_word;
        shf_n  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf <= '0;
      hold_q <= '0;
      rbf    <= 1'b0;
      shf    <= 1'b0;
      ovr    <= 1'b0;
    end else begin
      rx_buf <= buf_n;
      hold_q <= hold_n;
      rbf    <= rbf_n;
      shf    <= shf_n;
      if (ovr_set)      ovr <= 1'b1;
      else if (ovr_clr) ovr <= 1'b0;
    end
  end

  assign busy = shifting | shf;
endmodule

// File: rtl/mws_slave.sv
module mws_slave
  import mws_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int NARROW      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CW         = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_i,
  input  logic             cs_n_i,
  input  logic             mosi_i,
  output logic             miso_o,
  output logic             miso_oe_o,
  input  logic             wide_i,
  input  logic             echo_en_i,
  input  logic             ie_idle_i,
  input  logic             ie_rbf_i,
  input  logic             ie_ovr_i,
  input  logic             tx_wr_i,
  input  logic [WIDTH-1:0] tx_data_i,
  input  logic             rx_rd_i,
  input  logic             ovr_clr_i,
  output logic [WIDTH-1:0] rx_data_o,
  output logic             tx_valid_o,
  output logic             busy_o,
  output logic             rbf_o,
  output logic             ovr_o,
  output logic             irq_o
);
  logic [2:0]       pins_s;
  logic             sck_s, csa_s, mosi_s;
  logic             sck_d, csa_d;
  logic             rise, fall, cs_start;
  logic [WIDTH-1:0] tx_reg;
  logic             tx_take, frm_start, frm_done, out_bit, echo_act, shf;
  logic [WIDTH-1:0] rx_word;
  logic [CW-1:0]    bit_cnt;

  mws_sync #(.BITS(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({sck_i, ~cs_n_i, mosi_i}), .q_o(pins_s)
  );
  assign {sck_s, csa_s, mosi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      csa_d <= 1'b0;
    end else begin
      sck_d <= sck_s;
      csa_d <= csa_s;
    end
  end

  assign rise     = csa_s &  sck_s & ~sck_d;
  assign fall     = csa_s & ~sck_s &  sck_d;
  assign cs_start = csa_s & ~csa_d;

  // transmit holding register: a write wins over a same-cycle take
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_reg     <= '0;
      tx_valid_o <= 1'b0;
    end else if (tx_wr_i) begin
      tx_reg     <= tx_data_i;
      tx_valid_o <= 1'b1;
    end else if (tx_take) begin
      tx_valid_o <= 1'b0;
    end
  end

  mws_shifter #(.WIDTH(WIDTH), .NARROW(NARROW)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_act(csa_s), .cs_start(cs_start),
    .rise(rise), .fall(fall), .mosi_s(mosi_s), .wide(wide_i),
    .echo_en(echo_en_i), .tx_word(tx_reg), .tx_valid(tx_valid_o),
    .tx_take(tx_take), .frm_start(frm_start), .frm_done(frm_done),
    .rx_word(rx_word), .out_bit(out_bit), .echo_act(echo_act),
    .bit_cnt(bit_cnt)
  );

  mws_status #(.WIDTH(WIDTH)) u_stat (
    .clk(clk), .rst_n(rst_n), .frm_done(frm_done), .frm_start(frm_start),
    .rx_word(rx_word), .rx_rd(rx_rd_i), .ovr_clr(ovr_clr_i),
    .shifting(bit_cnt != '0), .rx_buf(rx_data_o), .rbf(rbf_o),
    .shf(shf), .ovr(ovr_o), .busy(busy_o)
  );

  assign miso_oe_o = ~cs_n_i;
  assign miso_o    = miso_oe_o & (echo_act ? mosi_i : out_bit);
  assign irq_o     = (ie_idle_i & ~busy_o) | (ie_rbf_i & rbf_o) | (ie_ovr_i & ovr_o);
endmodule

// File: rtl/mws_slave_chk.sv
module mws_slave_chk #(
  parameter int WIDTH  = 16,
  parameter int NARROW = 8,
  localparam int CW    = $clog2(WIDTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frm_start,
  input logic          frm_done,
  input logic          tx_take,
  input logic          tx_valid,
  input logic          rbf,
  input logic          shf,
  input logic          ovr,
  input logic          rd,
  input logic          wide,
  input logic          ie_rbf,
  input logic          irq,
  input logic [CW-1:0] cnt
);
  assert_frame_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |-> (cnt == '0) && ($past(cnt) == CW'(($past(wide) ? WIDTH : NARROW) - 1)));

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |=> !frm_done);

  assert_valid_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_valid) |-> $past(tx_take));

  assert_rbf_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rbf) |-> $past(rd));

  assert_park_needs_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    shf |-> rbf);

  assert_ovr_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(frm_start && rbf && shf));

  assert_irq_rbf_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_rbf && rbf) |-> irq);
endmodule

bind mws_slave mws_slave_chk #(.WIDTH(WIDTH), .NARROW(NARROW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_done(frm_done),
  .tx_take(tx_take), .tx_valid(tx_valid_o), .rbf(rbf_o), .shf(shf),
  .ovr(ovr_o), .rd(rx_rd_i), .wide(wide_i), .ie_rbf(ie_rbf_i),
  .irq(irq_o), .cnt(bit_cnt)
);

// File: tb/mws_slave_bench.sv
module mws_slave_bench;
  localparam int W = 16;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic wide = 1'b0, echo_en = 1'b0, ie_idle = 1'b0, ie_rbf = 1'b0, ie_ovr = 1'b0;
  logic tx_wr = 1'b0, rx_rd = 1'b0, ovr_clr = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic miso, miso_oe, tx_valid, busy, rbf, ovr, irq;
  logic [W-1:0] rx_data;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  mws_slave u_mws_slave (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .wide_i(wide), .echo_en_i(echo_en),
    .ie_idle_i(ie_idle), .ie_rbf_i(ie_rbf), .ie_ovr_i(ie_ovr),
    .tx_wr_i(tx_wr), .tx_data_i(tx_data), .rx_rd_i(rx_rd), .ovr_clr_i(ovr_clr),
    .rx_data_o(rx_data), .tx_valid_o(tx_valid), .busy_o(busy), .rbf_o(rbf),
    .ovr_o(ovr), .irq_o(irq)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic [W-1:0] d);
    tx_data = d; tx_wr = 1'b1; tick(1); tx_wr = 1'b0;
  endtask

  task automatic host_read();
    rx_rd = 1'b1; tick(1); rx_rd = 1'b0; tick(1);
  endtask

  // master: n bits, returns what it sampled just before each rising edge
  task automatic bits(input logic [W-1:0] mo, input int n, output logic [W-1:0] mi);
    mi = '0;
    for (int i = 0; i < n; i++) begin
      mosi = mo[n-1-i];
      tick(HALF);
      mi = {mi[W-2:0], miso};
      sck = 1'b1; tick(HALF); sck = 1'b0;
    end
  endtask

  task automatic frame(input logic [W-1:0] mo, input int n, output logic [W-1:0] mi);
    cs_n = 1'b0; tick(HALF);
    bits(mo, n, mi);
    tick(HALF); cs_n = 1'b1; tick(HALF);
  endtask

  function automatic logic [W-1:0] low8(input logic [W-1:0] v);
    return {8'h00, v[7:0]};
  endfunction

  task automatic t_reset();
    check("R1 oe idle", {15'b0, miso_oe}, 16'd0);
    check("R1 miso idle", {15'b0, miso}, 16'd0);
    check("R8 rbf reset", {15'b0, rbf}, 16'd0);
    check("R10 ovr reset", {15'b0, ovr}, 16'd0);
    check("R9 busy reset", {15'b0, busy}, 16'd0);
    check("R4 valid reset", {15'b0, tx_valid}, 16'd0);
  endtask

  task automatic t_narrow();
    logic [W-1:0] mi;
    wide = 1'b0;
    host_write(16'h3CA5);
    check("R4 valid set", {15'b0, tx_valid}, 16'd1);
    cs_n = 1'b0; tick(2);
    check("R1 oe active", {15'b0, miso_oe}, 16'd1);
    tick(HALF - 2);
    check("R4 valid cleared on load", {15'b0, tx_valid}, 16'd0);
    bits(16'h005C, 8, mi);
    tick(HALF); cs_n = 1'b1; tick(HALF);
    check("R3 narrow out", mi, 16'h00A5);
    check("R2 narrow in", rx_data, 16'h005C);
    check("R8 rbf set", {15'b0, rbf}, 16'd1);
    host_read();
    check("R8 rbf cleared", {15'b0, rbf}, 16'd0);
  endtask

  task automatic t_wide();
    logic [W-1:0] mi;
    wide = 1'b1;
    host_write(16'hBEEF);
    frame(16'h1234, 16, mi);
    check("R3 wide out", mi, 16'hBEEF);
    check("R2 wide in", rx_data, 16'h1234);
    host_read();
  endtask

  task automatic t_echo();
    logic [W-1:0] mi;
    wide = 1'b0; echo_en = 1'b1;
    frame(16'h0069, 8, mi);
    check("R5 echo out", mi, 16'h0069);
    check("R5 echo received", rx_data, 16'h0069);
    host_read();
    echo_en = 1'b0;
  endtask

  task automatic t_stale();
    logic [W-1:0] mi;
    wide = 1'b0;
    frame(16'h0042, 8, mi);
    check("R6 stale word sent", mi, 16'h00EF);
    check("R6 rx still taken", rx_data, 16'h0042);
    host_read();
  endtask

  task automatic t_resync();
    logic [W-1:0] mi;
    wide = 1'b0;
    cs_n = 1'b0; tick(HALF);
    bits(16'h0007, 3, mi);
    tick(HALF); cs_n = 1'b1; tick(HALF);
    check("R7 partial discarded", {15'b0, rbf}, 16'd0);
    check("R7 idle after abort", {15'b0, busy}, 16'd0);
    frame(16'h0081, 8, mi);
    check("R7 realigned", rx_data, 16'h0081);
    host_read();
  endtask

  task automatic t_park_and_overrun();
    logic [W-1:0] mi;
    wide = 1'b0; ie_ovr = 1'b1;
    frame(16'h0011, 8, mi);
    frame(16'h0022, 8, mi);
    check("R9 busy when parked", {15'b0, busy}, 16'd1);
    check("R9 buffer keeps first", rx_data, 16'h0011);
    check("R10 no ovr yet", {15'b0, ovr}, 16'd0);
    frame(16'h0033, 8, mi);
    check("R10 ovr set", {15'b0, ovr}, 16'd1);
    check("R11 irq on ovr", {15'b0, irq}, 16'd1);
    host_read();
    check("R9 parked moved", rx_data, 16'h0033);
    check("R9 rbf stays", {15'b0, rbf}, 16'd1);
    check("R9 not busy after move", {15'b0, busy}, 16'd0);
    host_read();
    check("R8 rbf empty", {15'b0, rbf}, 16'd0);
    ovr_clr = 1'b1; tick(1); ovr_clr = 1'b0; tick(1);
    check("R10 ovr cleared", {15'b0, ovr}, 16'd0);
    check("R11 irq off", {15'b0, irq}, 16'd0);
    ie_ovr = 1'b0;
  endtask

  task automatic t_irq();
    logic [W-1:0] mi;
    ie_idle = 1'b1; tick(1);
    check("R11 irq idle", {15'b0, irq}, 16'd1);
    ie_idle = 1'b0; ie_rbf = 1'b1; tick(1);
    check("R11 irq off empty", {15'b0, irq}, 16'd0);
    frame(16'h0055, 8, mi);
    check("R11 irq rbf", {15'b0, irq}, 16'd1);
    host_read();
    check("R11 irq rbf gone", {15'b0, irq}, 16'd0);
    ie_rbf = 1'b0;
  endtask

  task automatic t_back_to_back();
    logic [W-1:0] mi1, mi2;
    wide = 1'b0;
    host_write(16'h0011);
    cs_n = 1'b0; tick(HALF);
    host_write(16'h0022);
    bits(16'h00C3, 8, mi1);
    bits(16'h003C, 8, mi2);
    tick(HALF); cs_n = 1'b1; tick(HALF);
    check("R12 first word", mi1, 16'h0011);
    check("R12 second word", mi2, 16'h0022);
    check("R12 first rx", rx_data, 16'h00C3);
    host_read();
    check("R12 second rx", rx_data, 16'h003C);
    host_read();
    check("R1 miso low deselected", {15'b0, miso}, 16'd0);
  endtask

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_narrow();
    t_wide();
    t_echo();
    t_stale();
    t_resync();
    t_park_and_overrun();
    t_irq();
    t_back_to_back();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule